// File: doc/BRIEF.md
# Cascade Page-Address Enumeration Controller

This block holds the enumeration state of a chain of content-addressable memory devices that share one command bus and are ranked by a fixed priority. Each device keeps three things: a configuration word, a 4-bit page address and an active-low full flag. All of these are loaded through broadcast commands that every device sees at the same time.

A configuration broadcast loads the same word into every device. After that, a repeated write-page-address broadcast gives a different page address to each device in turn. Each write goes to the highest-ranked device that still reports empty, and that device then reports full. A later write therefore lands on the next device down the chain, and no device needs a unique address beforehand. A reset-full-flags broadcast returns every device to empty so the chain can be used normally or enumerated again.

The block signals when every device is full and all the page addresses it holds are different. It also raises a one-cycle overflow pulse when a write finds no empty device.

Top module: `pa_enum_ctrl`

## Requirements
- R1: After reset, every full flag is high (empty), every page address and configuration word is zero, done_o is low and overflow_o is low.
- R2: A accepted write-page-address command (cmd_op = 2'b01) loads cmd_data[3:0] into the page address of the lowest-index device whose full flag is high. It drives that flag low on the next clock edge and leaves every other device unchanged.
- R3: A write-page-address command that finds all flags low changes no page address and no flag. It raises overflow_o for exactly the one cycle after the command edge.
- R4: A reset-full-flags command (cmd_op = 2'b10) drives every full flag high on the next edge and keeps all page addresses.
- R5: A configuration command (cmd_op = 2'b00) loads the whole cmd_data word into the configuration word of every device. It leaves full flags and page addresses unchanged.
- R6: Write-page-address commands that arrive before the first configuration command since reset are ignored. They change no state and raise no overflow.
- R7: done_o is high exactly when every full flag is low and no two devices hold the same page address.
- R8: When cmd_valid is low, and for the reserved code cmd_op = 2'b11, the state does not change and overflow_o stays low.
- R9: Successive write-page-address commands fill devices in ascending index order. After a reset-full-flags command, the next write lands on device 0 again and overwrites its old address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 configure, 01 write page address, 10 reset full flags, 11 reserved |
| cmd_data | input | DATA_W (16) | Command payload; bits 3:0 carry the page address |
| page_addr_o | output | NUM_DEV*PA_W (16) | Page address of device i at bits [i*PA_W +: PA_W] |
| full_n_o | output | NUM_DEV (4) | Active-low full flag per device |
| cfg_o | output | NUM_DEV*DATA_W (64) | Configuration word of device i at bits [i*DATA_W +: DATA_W] |
| done_o | output | 1 | All devices full with distinct page addresses |
| overflow_o | output | 1 | One-cycle pulse: write found no empty device |

## Verification
The bench fills the chain one device at a time and checks after every write that exactly the expected device changed. A priority pick that chose the wrong end of the chain, or one that granted several devices, would show the wrong address in a neighbour's slot. It then writes into a full chain. A design that wrapped around or forgot to hold its state would overwrite device 0 or miss the overflow pulse. It enumerates again after a flag reset, once with a repeated value, so that done_o must stay low; a done that looked only at the flags would rise here. Writes before configuration, idle cycles and the reserved code must all leave every output unchanged.

// File: rtl/pa_enum_pkg.sv
package pa_enum_pkg;
    typedef enum logic [1:0] {
        OP_CFG   = 2'b00,
        OP_WRPA  = 2'b01,
        OP_RSTFF = 2'b10,
        OP_RSVD  = 2'b11
    } cmd_op_e;
endpackage

// File: rtl/pa_prio_pick.sv
module pa_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pick
            if (i == 0) begin : g_first
                assign grant[i] = req[i];
            end else begin : g_rest
                assign grant[i] = req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate
    assign any = |req;
endmodule

// File: rtl/pa_distinct.sv
module pa_distinct #(
    parameter int N    = 4,
    parameter int PA_W = 4
) (
    input  logic [N*PA_W-1:0] addrs,
    output logic              unique_o
);
    localparam int PAIRS = N * N;
    logic [PAIRS-1:0] diff;
    genvar i, j;
    generate
        for (i = 0; i < N; i++) begin : g_row
            for (j = 0; j < N; j++) begin : g_col
                if (j > i) begin : g_cmp
                    assign diff[i*N+j] = addrs[i*PA_W +: PA_W] != addrs[j*PA_W +: PA_W];
                end else begin : g_skip
                    assign diff[i*N+j] = 1'b1;
                end
            end
        end
    endgenerate
    assign unique_o = &diff;
endmodule

// File: rtl/pa_enum_ctrl.sv
module pa_enum_ctrl
    import pa_enum_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int PA_W    = 4,
    parameter int DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_op,
    input  logic [DATA_W-1:0]         cmd_data,
    output logic [NUM_DEV*PA_W-1:0]   page_addr_o,
    output logic [NUM_DEV-1:0]        full_n_o,
    output logic [NUM_DEV*DATA_W-1:0] cfg_o,
    output logic                      done_o,
    output logic                      overflow_o
);
    typedef struct packed {
        logic [NUM_DEV-1:0][PA_W-1:0]   pa;
        logic [NUM_DEV-1:0]             full_n;
        logic [NUM_DEV-1:0][DATA_W-1:0] cfg;
        logic                           configured;
        logic                           ovf;
    } state_t;

    state_t s_d, s_q;
    logic [NUM_DEV-1:0] grant;
    logic               any_empty;
    logic               all_unique;
    cmd_op_e            op;

    assign op = cmd_op_e'(cmd_op);

    pa_prio_pick #(.N(NUM_DEV)) u_pick (
        .req   (s_q.full_n),
        .grant (grant),
        .any   (any_empty)
    );

    pa_distinct #(.N(NUM_DEV), .PA_W(PA_W)) u_distinct (
        .addrs    (page_addr_o),
        .unique_o (all_unique)
    );

    always_comb begin
        s_d     = s_q;
        s_d.ovf = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_CFG: begin
                    for (int i = 0; i < NUM_DEV; i++) s_d.cfg[i] = cmd_data;
                    s_d.configured = 1'b1;
                end
                OP_WRPA: begin
                    if (s_q.configured) begin
                        if (any_empty) begin
                            for (int i = 0; i < NUM_DEV; i++) begin
                                if (grant[i]) begin
                                    s_d.pa[i]     = cmd_data[PA_W-1:0];
                                    s_d.full_n[i] = 1'b0;
                                end
                            end
                        end else begin
                            s_d.ovf = 1'b1;
                        end
                    end
                end
                OP_RSTFF: s_d.full_n = '1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.full_n <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign page_addr_o = s_q.pa;
    assign full_n_o    = s_q.full_n;
    assign cfg_o       = s_q.cfg;
    assign overflow_o  = s_q.ovf;
    assign done_o      = ~(|s_q.full_n) & all_unique;
endmodule

// File: rtl/pa_enum_ctrl_checker.sv
module pa_enum_ctrl_checker
    import pa_enum_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int PA_W    = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid,
    input logic [1:0]              cmd_op,
    input logic [NUM_DEV*PA_W-1:0] page_addr_o,
    input logic [NUM_DEV-1:0]      full_n_o,
    input logic                    done_o,
    input logic                    overflow_o
);
    assert_single_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OP_WRPA |=> $countones($past(full_n_o) & ~full_n_o) <= 1);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> ($stable(full_n_o) && $stable(page_addr_o) && (full_n_o == '0)));

    assert_flags_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OP_RSTFF |=> (full_n_o == '1) && $stable(page_addr_o));

    assert_cfg_keeps_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OP_CFG |=> $stable(full_n_o) && $stable(page_addr_o));

    assert_done_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (full_n_o == '0));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(full_n_o) && $stable(page_addr_o) && !overflow_o);
endmodule

bind pa_enum_ctrl pa_enum_ctrl_checker #(.NUM_DEV(NUM_DEV), .PA_W(PA_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .page_addr_o (page_addr_o),
    .full_n_o    (full_n_o),
    .done_o      (done_o),
    .overflow_o  (overflow_o)
);

// File: tb/pa_enum_ctrl_bench.sv
module pa_enum_ctrl_bench;
    localparam int N    = 4;
    localparam int PA_W = 4;
    localparam int DW   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic [DW-1:0]     cmd_data = '0;
    logic [N*PA_W-1:0] page_addr_o;
    logic [N-1:0]      full_n_o;
    logic [N*DW-1:0]   cfg_o;
    logic              done_o, overflow_o;

    pa_enum_ctrl #(.NUM_DEV(N), .PA_W(PA_W), .DATA_W(DW)) u_pa_enum_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .page_addr_o(page_addr_o), .full_n_o(full_n_o),
        .cfg_o(cfg_o), .done_o(done_o), .overflow_o(overflow_o)
    );

    typedef struct packed {
        logic [N*PA_W-1:0] pa;
        logic [N-1:0]      full_n;
        logic [N*DW-1:0]   cfg;
        logic              done;
        logic              ovf;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;

    logic [PA_W-1:0] m_pa [N];
    logic [N-1:0]    m_full_n;
    logic [DW-1:0]   m_cfg;
    logic            m_cfgd;
    logic            m_ovf;

    function automatic exp_t snap();
        exp_t e;
        logic uniq;
        for (int i = 0; i < N; i++) begin
            e.pa[i*PA_W +: PA_W] = m_pa[i];
            e.cfg[i*DW +: DW]    = m_cfg;
        end
        e.full_n = m_full_n;
        uniq = 1'b1;
        for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
                if (m_pa[i] == m_pa[j]) uniq = 1'b0;
        e.done = (m_full_n == '0) && uniq;
        e.ovf  = m_ovf;
        return e;
    endfunction

    task automatic model(input logic v, input logic [1:0] op, input logic [DW-1:0] d);
        bit hit;
        m_ovf = 1'b0;
        if (v) begin
            case (op)
                2'b00: begin m_cfg = d; m_cfgd = 1'b1; end
                2'b01: if (m_cfgd) begin
                    hit = 0;
                    for (int i = 0; i < N; i++) begin
                        if (!hit && m_full_n[i]) begin
                            m_pa[i] = d[PA_W-1:0];
                            m_full_n[i] = 1'b0;
                            hit = 1;
                        end
                    end
                    if (!hit) m_ovf = 1'b1;
                end
                2'b10: m_full_n = '1;
                default: ;
            endcase
        end
    endtask

    task automatic send(input logic v, input logic [1:0] op, input logic [DW-1:0] d, input string tag);
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = op;
        cmd_data  = d;
        model(v, op, d);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        exp_q.push_back(snap());
        tag_q.push_back(tag);
    endtask

    task automatic chk(input string tag, input string field, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, field, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "page_addr", 64'(page_addr_o), 64'(e.pa));
            chk(t, "full_n",    64'(full_n_o),    64'(e.full_n));
            chk(t, "cfg",       64'(cfg_o),       64'(e.cfg));
            chk(t, "done",      64'(done_o),      64'(e.done));
            chk(t, "overflow",  64'(overflow_o),  64'(e.ovf));
        end
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_pa[i] = '0;
        m_full_n = '1; m_cfg = '0; m_cfgd = 1'b0; m_ovf = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        exp_q.push_back(snap()); tag_q.push_back("R1 reset state");

        send(1'b1, 2'b01, 16'h0005, "R6 write before configure");
        send(1'b1, 2'b11, 16'h0007, "R8 reserved code");
        send(1'b0, 2'b01, 16'h0009, "R8 valid low");
        send(1'b1, 2'b00, 16'hA5C3, "R5 configure broadcast");
        send(1'b1, 2'b01, 16'hFFF3, "R2 R9 first write to device 0");
        send(1'b1, 2'b01, 16'h0007, "R2 R9 second write to device 1");
        send(1'b0, 2'b01, 16'h000E, "R8 idle mid enumeration");
        send(1'b1, 2'b01, 16'h0001, "R2 R9 third write to device 2");
        send(1'b1, 2'b01, 16'h0009, "R7 last write completes done");
        send(1'b1, 2'b01, 16'h0002, "R3 write into full chain");
        send(1'b1, 2'b11, 16'h0002, "R3 R8 pulse ends");
        send(1'b1, 2'b10, 16'h0000, "R4 reset full flags");
        send(1'b1, 2'b01, 16'h0004, "R9 rewrite device 0");
        send(1'b1, 2'b01, 16'h0004, "R7 duplicate value");
        send(1'b1, 2'b00, 16'h3C3C, "R5 configure mid enumeration");
        send(1'b1, 2'b01, 16'h0006, "R2 third device");
        send(1'b1, 2'b01, 16'h0008, "R7 full but duplicate no done");
        send(1'b1, 2'b10, 16'h0000, "R4 second flag reset");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule